// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM Core

This block is a synchronous static memory core that can take a new read, write or idle command on every clock edge. Reads and writes may follow each other in any mix without idle cycles. Read data comes out of an output register one clock edge after the command. Write data arrives two clock edges after its command. Because of this late write, the bus direction never has to turn around.

The data word is split into byte lanes, each with its own active-low write strobe. A command either loads an external address or continues a short wrapping burst. The burst steps through the next addresses in either counting order or XOR order. A suspend input freezes the whole pipeline. A nap input from a separate power controller turns incoming commands into deselects. The output-drive flag follows an asynchronous active-low drive input.

A read issued one cycle after a write to the same word gets the pending write data for that word. The data is merged lane by lane with the stored contents.

Top module: `zbt_sram_core`

## Requirements
- R1: A new operation loads only on an edge where `susp`=0, `burst_cont`=0, `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0 and `nap`=0. On that edge `addr`, `wr_n` and `lane_wr_n` are captured. If any of the three selects is invalid, the edge is a deselect.
- R2: Write data on `wr_data` is taken on the second enabled edge after the command edge. Lane i is bits [9i+8:9i], and it is stored only when `lane_wr_n[i]`=0 at the command edge.
- R3: A read command's data appears on `rd_data`, with `rd_drive`=1, after the next enabled edge. It stays there until the enabled edge after that.
- R4: With `burst_cont`=1, the k-th follow-on address keeps the upper address bits. Its low 2 bits are (base+k) mod 4 when `order_xor`=0, or base XOR k when `order_xor`=1. The sequence wraps after four addresses. The operation keeps the read or write type chosen at the load, whatever `wr_n` is.
- R5: While `susp`=1, edges change nothing: the output, the pending operations and the burst position all hold.
- R6: A deselect produces no output and no write. `burst_cont`=1 after a deselect continues the deselect.
- R7: A write with `lane_wr_n`=4'b1111 leaves the word unchanged.
- R8: When `drive_n`=1, `rd_drive`=0 and `rd_data`=0, so a read becomes a dummy read. `drive_n` acts without a clock edge.
- R9: A read one command after a write to the same address returns that write's data in the strobed lanes and the stored data in the other lanes.
- R10: Reset (`rst_n`=0, asynchronous) clears all pending operations and sets `rd_drive`=0.
- R11: While `nap`=1, load commands and burst continues are treated as deselects, and the memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| susp | input | 1 | High freezes the whole core for that edge |
| burst_cont | input | 1 | Low loads `addr`, high continues the burst |
| sel_a_n | input | 1 | Active-low select |
| sel_b | input | 1 | Active-high select |
| sel_c_n | input | 1 | Active-low select |
| wr_n | input | 1 | Low at load selects a write |
| lane_wr_n | input | 4 | Active-low byte lane write strobes |
| drive_n | input | 1 | Active-low asynchronous output drive enable |
| order_xor | input | 1 | Burst order: 0 counting, 1 XOR |
| nap | input | 1 | Sleep request from the power controller |
| addr | input | 6 | Word address |
| wr_data | input | 36 | Late write data |
| rd_data | output | 36 | Read data, zero when not driven |
| rd_drive | output | 1 | Output-enable flag for the pad ring |

## Verification
On one enabled edge, the core can commit a pending write into the array and also capture read data for the same word. That is where forwarding has to win over the stale array value. The bench provokes this with back-to-back write-then-read pairs to the same address, using both full-lane and partial-lane strobes. Each returned word is compared with a lane-wise merge computed in the bench from the previous reference contents. A suspended edge placed between a write command and its data checks that the two-edge gap counts enabled edges only.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;
   // largest address width the behavioural array may elaborate with
   localparam int ZBT_MAX_ADDR_W = 12;

   // kind of operation sitting in a pipeline slot
   typedef enum logic [1:0] {
      SLOT_EMPTY = 2'd0,
      SLOT_READ  = 2'd1,
      SLOT_WRITE = 2'd2
   } slot_e;
endpackage

// File: rtl/zbt_burst_seq.sv
`timescale 1ns/1ps
module zbt_burst_seq #(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              burst_cont,
   input  logic              sel_ok,
   input  logic              nap,
   input  logic              wr_n,
   input  logic              order_xor,
   input  logic [ADDR_W-1:0] addr,
   output logic              cmd_valid,
   output logic              cmd_wr,
   output logic [ADDR_W-1:0] cmd_addr
);
   logic              act_q;
   logic              wr_q;
   logic [ADDR_W-1:0] base_q;
   logic [BURST_W-1:0] cnt_q;

   logic [BURST_W-1:0] base_lo;
   logic [BURST_W-1:0] nxt_cnt;
   logic [BURST_W-1:0] step_lo;
   logic [ADDR_W-1:0]  cont_addr;

   assign base_lo = base_q[BURST_W-1:0];
   assign nxt_cnt = cnt_q + BURST_W'(1);
   assign step_lo = order_xor ? (base_lo ^ nxt_cnt) : (base_lo + nxt_cnt);

   // upper address bits only exist when the array is wider than a burst
   if (ADDR_W > BURST_W) begin : g_upper
      assign cont_addr = {base_q[ADDR_W-1:BURST_W], step_lo};
   end else begin : g_flat
      assign cont_addr = step_lo;
   end

   always_comb begin
      if (!burst_cont) begin
         cmd_valid = sel_ok;
         cmd_wr    = !wr_n;
         cmd_addr  = addr;
      end else begin
         cmd_valid = act_q && !nap;
         cmd_wr    = wr_q;
         cmd_addr  = cont_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         wr_q   <= 1'b0;
         base_q <= '0;
         cnt_q  <= '0;
      end else if (en) begin
         if (!burst_cont) begin
            act_q  <= sel_ok;
            wr_q   <= !wr_n;
            base_q <= addr;
            cnt_q  <= '0;
         end else if (cmd_valid) begin
            cnt_q <= nxt_cnt;
         end else begin
            act_q <= 1'b0;
         end
      end
   end

   // R4: a continue after a read load stays a read whatever wr_n shows
   a_r4_type_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !burst_cont && sel_ok && wr_n) ##1 (en && burst_cont && !nap)
      |-> (cmd_valid && !cmd_wr));

   // R6: a continue following a deselect never yields an operation
   a_r6_cont_desel: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !burst_cont && !sel_ok) ##1 (en && burst_cont) |-> !cmd_valid);
endmodule

// File: rtl/zbt_array.sv
`timescale 1ns/1ps
module zbt_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DW    = LANES * LANE_W,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [LANES-1:0]  lane_we,
   input  logic [DW-1:0]     wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DW-1:0]     rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int l = 0; l < LANES; l++) begin
            if (lane_we[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
         end
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/zbt_late_pipe.sv
`timescale 1ns/1ps
module zbt_late_pipe import zbt_pkg::*; #(
   parameter int ADDR_W    = 6,
   parameter int LANES     = 4,
   parameter int LANE_W    = 9,
   parameter bit BYPASS_EN = 1'b1,
   localparam int DW       = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cmd_valid,
   input  logic              cmd_wr,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LANES-1:0]  lane_wr_n,
   input  logic [DW-1:0]     wr_data,
   input  logic              drive_n,
   input  logic [DW-1:0]     arr_q,
   output logic [ADDR_W-1:0] arr_raddr,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_waddr,
   output logic [LANES-1:0]  arr_lane_we,
   output logic [DW-1:0]     arr_wdata,
   output logic [DW-1:0]     rd_data,
   output logic              rd_drive
);
   slot_e             s1_k, s2_k;
   logic [ADDR_W-1:0] s1_a, s2_a;
   logic [LANES-1:0]  s1_bw, s2_bw;
   logic              out_v;
   logic [DW-1:0]     out_q;
   logic [DW-1:0]     merged;
   logic              hit;

   // stage 1 reads the array; stage 2 commits with the late data
   assign arr_raddr   = s1_a;
   assign arr_we      = en && (s2_k == SLOT_WRITE);
   assign arr_waddr   = s2_a;
   assign arr_lane_we = ~s2_bw;
   assign arr_wdata   = wr_data;

   assign hit = (s2_k == SLOT_WRITE) && (s2_a == s1_a);

   if (BYPASS_EN) begin : g_bypass
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign merged[l*LANE_W +: LANE_W] = (hit && !s2_bw[l])
            ? wr_data[l*LANE_W +: LANE_W] : arr_q[l*LANE_W +: LANE_W];
      end
   end else begin : g_direct
      assign merged = arr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_k  <= SLOT_EMPTY;
         s2_k  <= SLOT_EMPTY;
         s1_a  <= '0;
         s2_a  <= '0;
         s1_bw <= '1;
         s2_bw <= '1;
         out_v <= 1'b0;
         out_q <= '0;
      end else if (en) begin
         s2_k  <= s1_k;
         s2_a  <= s1_a;
         s2_bw <= s1_bw;
         s1_k  <= !cmd_valid ? SLOT_EMPTY : (cmd_wr ? SLOT_WRITE : SLOT_READ);
         s1_a  <= cmd_addr;
         s1_bw <= lane_wr_n;
         out_v <= (s1_k == SLOT_READ);
         if (s1_k == SLOT_READ) out_q <= merged;
      end
   end

   assign rd_drive = out_v && !drive_n;
   assign rd_data  = rd_drive ? out_q : '0;

   // R2: a write command commits on the second enabled edge after it
   a_r2_late_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cmd_valid && cmd_wr) ##1 en ##1 en |-> arr_we);

   // R3: a read command has its data registered one enabled edge later
   a_r3_read_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cmd_valid && !cmd_wr) ##1 en |=> out_v);

   // R5: a suspended edge leaves every pipeline register untouched
   a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(out_q) && $stable(out_v) && $stable(s1_k) && $stable(s2_k)));
endmodule

// File: rtl/zbt_sram_core.sv
`timescale 1ns/1ps
module zbt_sram_core import zbt_pkg::*; #(
   parameter int ADDR_W    = 6,
   parameter int LANES     = 4,
   parameter int LANE_W    = 9,
   parameter int BURST_W   = 2,
   parameter bit BYPASS_EN = 1'b1,
   localparam int DW       = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              susp,
   input  logic              burst_cont,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              wr_n,
   input  logic [LANES-1:0]  lane_wr_n,
   input  logic              drive_n,
   input  logic              order_xor,
   input  logic              nap,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wr_data,
   output logic [DW-1:0]     rd_data,
   output logic              rd_drive
);
   // elaboration-time parameter checks
   if (ADDR_W < 1 || ADDR_W > ZBT_MAX_ADDR_W) begin : g_bad_addr
      $error("zbt_sram_core: ADDR_W out of range");
   end
   if (BURST_W < 1 || BURST_W > ADDR_W) begin : g_bad_burst
      $error("zbt_sram_core: BURST_W must be 1..ADDR_W");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("zbt_sram_core: lane geometry must be non-zero");
   end

   logic              en;
   logic              sel_ok;
   logic              cmd_valid;
   logic              cmd_wr;
   logic [ADDR_W-1:0] cmd_addr;
   logic [ADDR_W-1:0] arr_raddr;
   logic              arr_we;
   logic [ADDR_W-1:0] arr_waddr;
   logic [LANES-1:0]  arr_lane_we;
   logic [DW-1:0]     arr_wdata;
   logic [DW-1:0]     arr_q;

   assign en     = !susp;
   assign sel_ok = !sel_a_n && sel_b && !sel_c_n && !nap;

   zbt_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .burst_cont (burst_cont),
      .sel_ok     (sel_ok),
      .nap        (nap),
      .wr_n       (wr_n),
      .order_xor  (order_xor),
      .addr       (addr),
      .cmd_valid  (cmd_valid),
      .cmd_wr     (cmd_wr),
      .cmd_addr   (cmd_addr)
   );

   zbt_late_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .BYPASS_EN(BYPASS_EN)) u_pipe (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .cmd_valid   (cmd_valid),
      .cmd_wr      (cmd_wr),
      .cmd_addr    (cmd_addr),
      .lane_wr_n   (lane_wr_n),
      .wr_data     (wr_data),
      .drive_n     (drive_n),
      .arr_q       (arr_q),
      .arr_raddr   (arr_raddr),
      .arr_we      (arr_we),
      .arr_waddr   (arr_waddr),
      .arr_lane_we (arr_lane_we),
      .arr_wdata   (arr_wdata),
      .rd_data     (rd_data),
      .rd_drive    (rd_drive)
   );

   zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk     (clk),
      .we      (arr_we),
      .waddr   (arr_waddr),
      .lane_we (arr_lane_we),
      .wdata   (arr_wdata),
      .raddr   (arr_raddr),
      .rdata   (arr_q)
   );

   // R6: deselect then continue-deselect leaves the output undriven
   a_r6_no_output: assert property (@(posedge clk) disable iff (!rst_n)
      (!susp && !burst_cont && (sel_a_n || !sel_b || sel_c_n)) ##1 (!susp && burst_cont) ##1 !susp
      |=> !rd_drive);

   // R11: a command taken while napping produces no read output
   a_r11_nap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (nap && !susp) ##1 !susp |=> !rd_drive);

   // R8: with drive disabled nothing reaches the bus
   always_comb begin
      if (rst_n && drive_n) a_r8_undriven: assert (!rd_drive && rd_data == '0);
   end
endmodule

// File: tb/sim_zbt_sram_core.sv
`timescale 1ns/1ps
module sim_zbt_sram_core;
   logic        clk = 1'b0;
   logic        rst_n, susp, burst_cont, sel_a_n, sel_b, sel_c_n, wr_n;
   logic [3:0]  lane_wr_n;
   logic        drive_n, order_xor, nap;
   logic [5:0]  addr;
   logic [35:0] wr_data, rd_data;
   logic        rd_drive;

   int checks = 0;
   int fails  = 0;
   logic [35:0] ref_m [64];

   always #4 clk = ~clk;

   zbt_sram_core u0 (
      .clk(clk), .rst_n(rst_n), .susp(susp), .burst_cont(burst_cont),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_n(wr_n),
      .lane_wr_n(lane_wr_n), .drive_n(drive_n), .order_xor(order_xor), .nap(nap),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
   );

   function automatic logic [35:0] pat(input int k);
      logic [35:0] x;
      x = 36'(k) * 36'd2654435761;
      return x ^ 36'h5A5A5A5A5;
   endfunction

   function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw, input logic [3:0] bw);
      logic [35:0] r;
      r = old;
      for (int l = 0; l < 4; l++) if (!bw[l]) r[l*9 +: 9] = nw[l*9 +: 9];
      return r;
   endfunction

   task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cmd(input logic load, input logic sel, input logic wr, input logic [3:0] bw, input logic [5:0] a);
      burst_cont = !load;
      sel_a_n = !sel; sel_b = sel; sel_c_n = !sel;
      wr_n = !wr; lane_wr_n = bw; addr = a;
   endtask

   task automatic ds();
      cmd(1'b1, 1'b0, 1'b0, 4'hF, 6'd0);
   endtask

   task automatic wr_single(input logic [5:0] a, input logic [3:0] bw, input logic [35:0] d);
      cmd(1'b1, 1'b1, 1'b1, bw, a); tick();
      ds(); tick();
      wr_data = d; tick();
      wr_data = '0;
      ref_m[a] = merge(ref_m[a], d, bw);
   endtask

   task automatic rd_single(input logic [5:0] a, output logic [35:0] d, output logic drv);
      cmd(1'b1, 1'b1, 1'b0, 4'hF, a); tick();
      ds(); tick();
      d = rd_data; drv = rd_drive;
   endtask

   initial begin
      #(8 * 200000);
      checks++; fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [35:0] d;
      logic        drv;
      rst_n = 1'b0; susp = 1'b0; drive_n = 1'b0; order_xor = 1'b0; nap = 1'b0;
      wr_data = '0; ds();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R10: reset state
      chk("R10 reset drive", 36'(rd_drive), 36'd0);
      chk("R10 reset data", rd_data, 36'd0);

      // R2 sweep: back-to-back writes to every word, data two edges late
      for (int i = 0; i < 66; i++) begin
         if (i < 64) cmd(1'b1, 1'b1, 1'b1, 4'h0, 6'(i)); else ds();
         wr_data = (i >= 2) ? pat(i - 2) : '0;
         tick();
         if (i >= 2) ref_m[i - 2] = pat(i - 2);
      end
      wr_data = '0;

      // R3 / R1 sweep: back-to-back reads, data one edge later
      for (int i = 0; i < 65; i++) begin
         if (i < 64) cmd(1'b1, 1'b1, 1'b0, 4'hF, 6'(i)); else ds();
         tick();
         if (i >= 1) begin
            chk("R3 read data", rd_data, ref_m[i - 1]);
            chk("R1 read drive", 36'(rd_drive), 36'd1);
         end
      end

      // R9: write then immediate read of the same word, partial lanes
      cmd(1'b1, 1'b1, 1'b1, 4'b0101, 6'h21); tick();
      cmd(1'b1, 1'b1, 1'b0, 4'hF, 6'h21); tick();
      ds(); wr_data = 36'hABCDE1234; tick(); wr_data = '0;
      ref_m[6'h21] = merge(ref_m[6'h21], 36'hABCDE1234, 4'b0101);
      chk("R9 forward partial", rd_data, ref_m[6'h21]);

      // R9: alternating write/read chain with no idle cycles
      for (int j = 0; j < 10; j++) begin
         if (j < 8) begin
            if (j % 2 == 0) cmd(1'b1, 1'b1, 1'b1, 4'h0, 6'(40 + j / 2));
            else            cmd(1'b1, 1'b1, 1'b0, 4'hF, 6'(40 + j / 2));
         end else ds();
         wr_data = (j >= 2 && j % 2 == 0) ? pat(100 + j - 2) : '0;
         tick();
         if (j >= 2 && j % 2 == 0) begin
            ref_m[40 + (j - 2) / 2] = pat(100 + j - 2);
            chk("R9 forward chain", rd_data, pat(100 + j - 2));
         end
      end
      wr_data = '0;

      // R2 / R7: every strobe pattern on one word
      for (int m = 0; m < 16; m++) begin
         wr_single(6'd10, 4'(m), pat(200 + m));
         rd_single(6'd10, d, drv);
         chk((m == 15) ? "R7 abort keeps word" : "R2 lane strobes", d, ref_m[10]);
      end

      // R4: counting-order write burst from 0x1D, type kept with wr_n high
      order_xor = 1'b0;
      for (int c = 0; c < 6; c++) begin
         if (c == 0) cmd(1'b1, 1'b1, 1'b1, 4'h0, 6'h1D);
         else if (c < 4) begin burst_cont = 1'b1; wr_n = 1'b1; lane_wr_n = 4'h0; end
         else ds();
         wr_data = (c >= 2) ? pat(300 + c - 2) : '0;
         tick();
         if (c >= 2) ref_m[6'h1C | 6'((1 + c - 2) & 3)] = pat(300 + c - 2);
      end
      wr_data = '0;
      for (int k = 0; k < 4; k++) begin
         rd_single(6'h1C | 6'((1 + k) & 3), d, drv);
         chk("R4 linear burst order", d, pat(300 + k));
      end

      // R4: XOR-order read burst from 0x1E, five beats to show the wrap
      order_xor = 1'b1;
      for (int c = 0; c < 6; c++) begin
         if (c == 0) cmd(1'b1, 1'b1, 1'b0, 4'hF, 6'h1E);
         else if (c < 5) begin burst_cont = 1'b1; wr_n = 1'b0; lane_wr_n = 4'h0; end
         else ds();
         tick();
         if (c >= 1) chk("R4 xor burst order", rd_data, ref_m[6'h1C | 6'(2 ^ ((c - 1) & 3))]);
      end
      order_xor = 1'b0;
      tick();
      chk("R4 burst stays idle after end", 36'(rd_drive), 36'd0);
      rd_single(6'h1C, d, drv);
      chk("R4 read burst wrote nothing", d, ref_m[6'h1C]);

      // R5: suspend freezes the output and the write data slot
      ds(); tick();
      cmd(1'b1, 1'b1, 1'b0, 4'hF, 6'd7); tick();
      susp = 1'b1; cmd(1'b1, 1'b1, 1'b0, 4'hF, 6'd9); tick();
      chk("R5 frozen before output", 36'(rd_drive), 36'd0);
      tick();
      susp = 1'b0; ds(); tick();
      chk("R5 read after thaw", rd_data, ref_m[7]);
      susp = 1'b1; cmd(1'b1, 1'b1, 1'b0, 4'hF, 6'd9); tick(); tick();
      chk("R5 output held", rd_data, ref_m[7]);
      susp = 1'b0; ds(); tick();
      chk("R5 output drops", 36'(rd_drive), 36'd0);
      cmd(1'b1, 1'b1, 1'b1, 4'h0, 6'd12); tick();
      susp = 1'b1; wr_data = 36'hFFFFFFFFF; tick();
      susp = 1'b0; ds(); tick();
      wr_data = pat(400); tick(); wr_data = '0;
      ref_m[12] = pat(400);
      rd_single(6'd12, d, drv);
      chk("R5 write counts enabled edges", d, ref_m[12]);

      // R6: deselected write, then continues
      cmd(1'b1, 1'b0, 1'b1, 4'h0, 6'd5); tick();
      burst_cont = 1'b1; wr_n = 1'b0; tick();
      chk("R6 no output", 36'(rd_drive), 36'd0);
      wr_data = 36'h0DEADBEEF; tick();
      chk("R6 continue deselect", 36'(rd_drive), 36'd0);
      ds(); tick(); wr_data = '0;
      rd_single(6'd5, d, drv);
      chk("R6 word untouched", d, ref_m[5]);

      // R8: dummy read, then asynchronous drive enable
      drive_n = 1'b1;
      rd_single(6'd7, d, drv);
      chk("R8 dummy drive", 36'(drv), 36'd0);
      chk("R8 dummy data", d, 36'd0);
      drive_n = 1'b0; #1;
      chk("R8 async enable", rd_data, ref_m[7]);
      tick();

      // R1: each select invalid on its own gives a deselect
      for (int v = 0; v < 3; v++) begin
         cmd(1'b1, 1'b1, 1'b0, 4'hF, 6'd3);
         if (v == 0) sel_a_n = 1'b1;
         if (v == 1) sel_b = 1'b0;
         if (v == 2) sel_c_n = 1'b1;
         tick(); ds(); tick();
         chk("R1 select invalid", 36'(rd_drive), 36'd0);
      end

      // R11: nap turns commands into deselects and keeps contents
      nap = 1'b1; cmd(1'b1, 1'b1, 1'b0, 4'hF, 6'd3); tick();
      nap = 1'b0; ds(); tick();
      chk("R11 nap read", 36'(rd_drive), 36'd0);
      nap = 1'b1; cmd(1'b1, 1'b1, 1'b1, 4'h0, 6'd6); tick();
      nap = 1'b0; ds(); tick();
      wr_data = 36'h123456789; tick(); wr_data = '0;
      rd_single(6'd6, d, drv);
      chk("R11 nap write kept", d, ref_m[6]);
      cmd(1'b1, 1'b1, 1'b0, 4'hF, 6'd3); tick();
      nap = 1'b1; burst_cont = 1'b1; tick();
      nap = 1'b0; ds(); tick();
      chk("R11 nap continue", 36'(rd_drive), 36'd0);

      // R10: asynchronous reset mid-read
      cmd(1'b1, 1'b1, 1'b0, 4'hF, 6'd3); tick();
      ds(); tick();
      chk("R10 pre-reset drive", 36'(rd_drive), 36'd1);
      rst_n = 1'b0; #1;
      chk("R10 async clear", 36'(rd_drive), 36'd0);
      tick(); rst_n = 1'b1; tick();
      chk("R10 after reset", 36'(rd_drive), 36'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule